// File: doc/BRIEF.md
# Programmable-Format Serial Frame Transmitter

This block turns characters written by a host into asynchronous serial frames on a single output line. The line rests high. Each frame opens with a low start bit. Next come the character bits, least significant first, then an optional parity bit, then one or two high stop bits. The character size, parity mode and stop-bit count are control inputs. They are captured when a character moves into the shift register, so the format can be changed for the next character while the current one is still going out.

There are two storage stages: a holding register for the next character and a shift register for the character on the line. A host can therefore queue a second character while the first is being sent, and the two frames follow each other with no idle gap. There are two status flags. One shows that the holding register is free. The other shows that the line has gone quiet after the last stop bit. Each flag drives an interrupt request that has its own enable. Bit timing comes from a 16-bit divisor, and a speed-select input sets the number of clocks per bit.

Top module: `sertx_frame`

## Requirements
- R1: After reset the line is high, the holding-free flag is 1, the line-quiet flag is 0 and both interrupt requests are 0. Whenever no frame is in progress, the line is high.
- R2: A frame is one start bit at 0, then the character bits least significant first, then the parity bit when parity is enabled, then the stop bits at 1.
- R3: With speed select 0 each bit lasts 16 × (divisor + 1) clocks. With speed select 1 each bit lasts 8 × (divisor + 1) clocks.
- R4: The 3-bit size code selects the character length: 000 gives 5 bits, 001 gives 6, 010 gives 7, 011 gives 8 and 111 gives 9. Any other code gives 8. In 9-bit mode the ninth bit is the value on wr_bit8 at the time of the write.
- R5: The 2-bit parity code selects the parity bit: 00 sends no parity bit and 01 is treated the same way. With 10 (even) the parity bit is 1 when the character holds an odd number of ones. With 11 (odd) the parity bit is 1 when the character holds an even number of ones.
- R6: two_stop = 0 sends one stop bit and two_stop = 1 sends two.
- R7: A write clears the holding-free flag on the next clock. The flag sets again when the character moves into the shift register. A character queued while a frame is on the line starts exactly when the last stop bit of that frame ends.
- R8: The line-quiet flag sets when the last stop bit ends and no further character starts at that moment. It stays 0 while a queued character follows on directly. A pulse on done_clr clears it.
- R9: Each interrupt request equals its flag ANDed with its enable.
- R10: When tx_enable goes low, a frame already in progress finishes unchanged. After that no new frame starts, and a queued character is held until tx_enable returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character bits 7..0 |
| wr_bit8 | input | 1 | Ninth character bit, used in 9-bit mode |
| tx_enable | input | 1 | Allows new frames to start |
| size_code | input | 3 | Character size code |
| par_mode | input | 2 | Parity code |
| two_stop | input | 1 | Stop-bit count select |
| divisor | input | 16 | Bit-time divisor |
| dbl_speed | input | 1 | Selects 8 instead of 16 clocks per divisor step |
| done_clr | input | 1 | Clears the line-quiet flag |
| empty_ie | input | 1 | Interrupt enable for the holding-free flag |
| done_ie | input | 1 | Interrupt enable for the line-quiet flag |
| txd | output | 1 | Serial line |
| empty_flag | output | 1 | Holding register free |
| done_flag | output | 1 | Line quiet after the last stop bit |
| empty_irq | output | 1 | Holding-free interrupt request |
| done_irq | output | 1 | Line-quiet interrupt request |

## Verification
The hardest condition to reach from the ports is the clock edge where the last stop bit ends while a second character is waiting. At that edge the handoff must start the next frame without a gap and must keep the line-quiet flag clear. The bench writes the second character one clock after the first one is loaded. It then checks the two frames as one continuous bit sequence at mid-bit points. In a variant of this test, tx_enable is dropped during the first frame, which leaves a character stranded in the holding register. The bench then confirms that the line stays high and that this character goes out intact once tx_enable returns high.

// File: rtl/sertx_pkg.sv
// Shared constants, the parity-mode type and the size decode for the
// serial frame transmitter. Assumes at most 9 character bits per frame.
package sertx_pkg;
    localparam int unsigned CHAR_MAX = 9;
    localparam int unsigned FRAME_W  = CHAR_MAX + 4;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_RSVD = 2'b01,
        PAR_EVEN = 2'b10,
        PAR_ODD  = 2'b11
    } par_mode_e;

    // Size code to number of character bits; unlisted codes mean 8.
    function automatic logic [3:0] char_len(input logic [2:0] code);
        case (code)
            3'b000:  return 4'd5;
            3'b001:  return 4'd6;
            3'b010:  return 4'd7;
            3'b111:  return 4'd9;
            default: return 4'd8;
        endcase
    endfunction
endpackage

// File: rtl/sertx_pack.sv
// Combinational frame builder: places start, character, parity and stop
// bits into one vector, with bit 0 sent first, and reports how many bits
// the frame has. Positions past the frame length are filled with 1.
// Assumes FW is at least CHAR_MAX + 4.
module sertx_pack
    import sertx_pkg::*;
#(
    parameter int unsigned FW = FRAME_W
) (
    input  logic [CHAR_MAX-1:0] chr,
    input  logic [2:0]          size_code,
    input  logic [1:0]          par_mode,
    input  logic                two_stop,
    output logic [FW-1:0]       frame,
    output logic [3:0]          nbits
);
    logic [3:0] n;
    logic       ones;
    logic       par_en;
    logic       par_bit;

    // Build the frame vector and its length from the format fields.
    always_comb begin
        n      = char_len(size_code);
        par_en = par_mode[1];
        ones   = 1'b0;
        frame  = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < int'(CHAR_MAX); i++) begin
            if (i < int'(n)) begin
                frame[i+1] = chr[i];
                ones       = ones ^ chr[i];
            end
        end
        par_bit = (par_mode == PAR_ODD) ? ~ones : ones;
        if (par_en) frame[n + 4'd1] = par_bit;
        nbits = 4'd2 + n + {3'b000, par_en} + {3'b000, two_stop};
    end
endmodule

// File: rtl/sertx_baud.sv
// Bit-time counter: while run is high it produces one tick every
// last + 1 clocks. It rests at zero while idle. The >= compare makes it
// recover within one clock if last shrinks during a frame.
// Assumes last is at least 1.
module sertx_baud #(
    parameter int unsigned CW = 21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] last,
    output logic          tick
);
    logic [CW-1:0] cnt;

    assign tick = run && (cnt >= last);

    // Count clocks within the current bit; restart at each bit boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (!run || tick)  cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end

    a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/sertx_shift.sv
// Frame shift register: loads a built frame and shifts one bit out per
// tick until the count of frame bits reaches zero. frame_end marks the
// tick that closes the last stop bit. Assumes load is only asserted
// when idle or on frame_end.
module sertx_shift #(
    parameter int unsigned FW = 13,
    parameter int unsigned LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [FW-1:0] frame,
    input  logic [LW-1:0] nbits,
    input  logic          tick,
    output logic          txd,
    output logic          busy,
    output logic          frame_end
);
    logic [FW-1:0] sr;
    logic [LW-1:0] left;

    assign frame_end = busy && tick && (left == LW'(1));
    assign txd       = busy ? sr[0] : 1'b1;

    // Load a new frame or step to the next bit on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            sr   <= '1;
            left <= '0;
        end else if (load) begin
            busy <= 1'b1;
            sr   <= frame;
            left <= nbits;
        end else if (busy && tick) begin
            sr   <= {1'b1, sr[FW-1:1]};
            left <= left - 1'b1;
            if (left == LW'(1)) busy <= 1'b0;
        end
    end

    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd);
    a_r6_last_is_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && left == LW'(1)) |-> txd);
    a_r7_load_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (!busy || frame_end));
endmodule

// File: rtl/sertx_frame.sv
// Top level of the serial frame transmitter: a holding register in front
// of the shift stage, a bit-time counter, and two status flags with
// masked interrupt requests. Format fields are sampled when a character
// moves from the holding register into the shift register.
module sertx_frame
    import sertx_pkg::*;
#(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             wr_bit8,
    input  logic             tx_enable,
    input  logic [2:0]       size_code,
    input  logic [1:0]       par_mode,
    input  logic             two_stop,
    input  logic [DIV_W-1:0] divisor,
    input  logic             dbl_speed,
    input  logic             done_clr,
    input  logic             empty_ie,
    input  logic             done_ie,
    output logic             txd,
    output logic             empty_flag,
    output logic             done_flag,
    output logic             empty_irq,
    output logic             done_irq
);
    localparam int unsigned CW = DIV_W + 5;
    localparam int unsigned LW = 4;

    logic                hold_full;
    logic [CHAR_MAX-1:0] hold_chr;
    logic                done_q;
    logic                busy;
    logic                frame_end;
    logic                tick;
    logic                load;
    logic [FRAME_W-1:0]  frame;
    logic [LW-1:0]       nbits;
    logic [CW-1:0]       span;
    logic [CW-1:0]       last;

    assign load = hold_full && tx_enable && (!busy || frame_end);
    assign span = ({{5{1'b0}}, divisor} + CW'(1)) << (dbl_speed ? 3 : 4);
    assign last = span - CW'(1);

    // Holding register: a write fills it, and a move to the shifter frees it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_full <= 1'b0;
            hold_chr  <= '0;
        end else if (wr_en) begin
            hold_full <= 1'b1;
            hold_chr  <= {wr_bit8, wr_data};
        end else if (load) begin
            hold_full <= 1'b0;
        end
    end

    // Line-quiet flag: set when a frame closes with no follower; a set beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                   done_q <= 1'b0;
        else if (frame_end && !load)  done_q <= 1'b1;
        else if (done_clr)            done_q <= 1'b0;
    end

    sertx_pack #(.FW(FRAME_W)) u_pack (
        .chr       (hold_chr),
        .size_code (size_code),
        .par_mode  (par_mode),
        .two_stop  (two_stop),
        .frame     (frame),
        .nbits     (nbits)
    );

    sertx_baud #(.CW(CW)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .last  (last),
        .tick  (tick)
    );

    sertx_shift #(.FW(FRAME_W), .LW(LW)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .frame     (frame),
        .nbits     (nbits),
        .tick      (tick),
        .txd       (txd),
        .busy      (busy),
        .frame_end (frame_end)
    );

    assign empty_flag = !hold_full;
    assign done_flag  = done_q;
    assign empty_irq  = empty_flag && empty_ie;
    assign done_irq   = done_flag && done_ie;

    a_r7_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !empty_flag);
    a_r8_done_on_close: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_flag);
    a_r10_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_enable && !busy) |=> !busy);
    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);
endmodule

// File: tb/sertx_frame_bench.sv
`timescale 1ns/1ps
module sertx_frame_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [7:0]  wr_data;
    logic        wr_bit8;
    logic        tx_enable;
    logic [2:0]  size_code;
    logic [1:0]  par_mode;
    logic        two_stop;
    logic [15:0] divisor;
    logic        dbl_speed;
    logic        done_clr;
    logic        empty_ie;
    logic        done_ie;
    logic        txd;
    logic        empty_flag;
    logic        done_flag;
    logic        empty_irq;
    logic        done_irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sertx_frame u_sertx_frame (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_bit8(wr_bit8), .tx_enable(tx_enable), .size_code(size_code),
        .par_mode(par_mode), .two_stop(two_stop), .divisor(divisor),
        .dbl_speed(dbl_speed), .done_clr(done_clr), .empty_ie(empty_ie),
        .done_ie(done_ie), .txd(txd), .empty_flag(empty_flag),
        .done_flag(done_flag), .empty_irq(empty_irq), .done_irq(done_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected frame bits from the requirements (R2, R4, R5, R6).
    task automatic build(input logic [8:0] d, input logic [2:0] sz,
                         input logic [1:0] pm, input logic st,
                         output logic [31:0] v, output int len);
        int n;
        int ones;
        n = (sz == 3'd0) ? 5 : (sz == 3'd1) ? 6 : (sz == 3'd2) ? 7 :
            (sz == 3'd7) ? 9 : 8;
        ones = 0;
        v = '1;
        v[0] = 1'b0;
        for (int i = 0; i < n; i++) begin
            v[i+1] = d[i];
            ones += int'(d[i]);
        end
        len = 1 + n;
        if (pm == 2'b10) begin v[len] = (ones % 2 == 1); len++; end
        else if (pm == 2'b11) begin v[len] = (ones % 2 == 0); len++; end
        len += st ? 2 : 1;
    endtask

    // Drive a write at a falling edge; returns half a clock before the load edge.
    task automatic write_char(input logic [8:0] d, input bit clr);
        @(negedge clk);
        wr_data  = d[7:0];
        wr_bit8  = d[8];
        wr_en    = 1'b1;
        done_clr = clr;
        @(negedge clk);
        wr_en    = 1'b0;
        done_clr = 1'b0;
    endtask

    // Sample each bit at its midpoint; the first sample comes first_wait rising edges later.
    task automatic sample_frame(input logic [31:0] v, input int len, input int L,
                                input int first_wait, input int drop_bit,
                                input int exp_empty0, input string tag);
        repeat (first_wait) @(posedge clk);
        @(negedge clk);
        for (int b = 0; b < len; b++) begin
            chk(tag, int'(txd), int'(v[b]));
            if (b == 0 && exp_empty0 >= 0) chk("R7 holding flag at first bit", int'(empty_flag), exp_empty0);
            if (b == len - 1) chk("R8 quiet flag low during frame", int'(done_flag), 0);
            if (b == drop_bit) tx_enable = 1'b0;
            if (b < len - 1) begin
                repeat (L) @(posedge clk);
                @(negedge clk);
            end
        end
        repeat (L / 2) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_fmt(input logic [2:0] sz, input logic [1:0] pm, input logic st,
                           input logic [15:0] dv, input logic dbl);
        size_code = sz; par_mode = pm; two_stop = st; divisor = dv; dbl_speed = dbl;
    endtask

    task automatic one_frame(input logic [8:0] d, input logic [2:0] sz, input logic [1:0] pm,
                             input logic st, input logic [15:0] dv, input logic dbl,
                             input string tag);
        logic [31:0] v;
        int len;
        int L;
        L = (int'(dv) + 1) * (dbl ? 8 : 16);
        build(d, sz, pm, st, v, len);
        set_fmt(sz, pm, st, dv, dbl);
        write_char(d, 1'b1);
        sample_frame(v, len, L, L / 2 + 1, -1, 1, tag);
        chk("R8 quiet flag after last stop", int'(done_flag), 1);
        chk("R7 holding flag after frame", int'(empty_flag), 1);
        chk("R1 line high after frame", int'(txd), 1);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int szl[6] = '{0, 1, 2, 3, 7, 5};
        logic [8:0] dl[3] = '{9'h1A5, 9'h05A, 9'h13C};
        logic [31:0] va, vb, vab;
        int la, lb, L, bad;

        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; wr_bit8 = 1'b0; tx_enable = 1'b1;
        size_code = 3'd3; par_mode = 2'b00; two_stop = 1'b0; divisor = '0;
        dbl_speed = 1'b1; done_clr = 1'b0; empty_ie = 1'b0; done_ie = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset line", int'(txd), 1);
        chk("R1 reset holding flag", int'(empty_flag), 1);
        chk("R1 reset quiet flag", int'(done_flag), 0);
        chk("R1 reset irq empty", int'(empty_irq), 0);
        chk("R1 reset irq done", int'(done_irq), 0);

        // R2 R4 R5 R6: sweep size, parity and stop codes at 8 clocks per bit.
        foreach (szl[s])
            for (int pm = 0; pm < 4; pm++)
                for (int st = 0; st < 2; st++)
                    for (int k = 0; k < 3; k++)
                        one_frame(dl[k], 3'(szl[s]), 2'(pm), st[0], 16'd0, 1'b1,
                                  "R2 R4 R5 R6 frame bit");

        // R3: other bit lengths.
        one_frame(9'h0C3, 3'd3, 2'b10, 1'b0, 16'd2, 1'b0, "R3 bit at 48 clocks");
        one_frame(9'h136, 3'd7, 2'b11, 1'b1, 16'd1, 1'b1, "R3 bit at 16 clocks dbl");
        one_frame(9'h02D, 3'd2, 2'b00, 1'b0, 16'd0, 1'b0, "R3 bit at 16 clocks");

        // R3: start bit width exactly 48 clocks, then 24.
        for (int m = 0; m < 2; m++) begin
            L = m == 0 ? 48 : 24;
            set_fmt(3'd3, 2'b00, 1'b0, 16'd2, m[0]);
            write_char(9'h001, 1'b1);
            @(negedge clk);
            chk("R3 start begins", int'(txd), 0);
            repeat (L - 1) @(posedge clk);
            @(negedge clk);
            chk("R3 start still low at last clock", int'(txd), 0);
            @(negedge clk);
            chk("R3 first data after start", int'(txd), 1);
            repeat (L * 11) @(negedge clk);
            chk("R8 quiet after width test", int'(done_flag), 1);
        end

        // R7 R8: back-to-back characters with no gap.
        L = 8;
        set_fmt(3'd3, 2'b10, 1'b0, 16'd0, 1'b1);
        build(9'h0B1, 3'd3, 2'b10, 1'b0, va, la);
        build(9'h04E, 3'd3, 2'b10, 1'b0, vb, lb);
        vab = (vb << la) | (va & ((32'd1 << la) - 1));
        write_char(9'h0B1, 1'b1);
        write_char(9'h04E, 1'b0);
        chk("R7 holding flag low with queued char", int'(empty_flag), 0);
        sample_frame(vab, la + lb, L, L / 2 - 1, -1, -1, "R7 back-to-back bit");
        chk("R8 quiet after pair", int'(done_flag), 1);
        chk("R7 holding free after pair", int'(empty_flag), 1);

        // R10: drop enable mid-frame with a character queued.
        set_fmt(3'd0, 2'b11, 1'b1, 16'd0, 1'b1);
        build(9'h015, 3'd0, 2'b11, 1'b1, va, la);
        build(9'h00A, 3'd0, 2'b11, 1'b1, vb, lb);
        write_char(9'h015, 1'b1);
        write_char(9'h00A, 1'b0);
        sample_frame(va, la, L, L / 2 - 1, 2, -1, "R10 frame finishes after disable");
        chk("R10 quiet set with char held", int'(done_flag), 1);
        chk("R10 char still held", int'(empty_flag), 0);
        bad = 0;
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            if (txd !== 1'b1) bad++;
        end
        chk("R10 line idle while disabled", bad, 0);

        // R9: interrupt masking while one flag is 1 and the other 0.
        done_ie = 1'b1; empty_ie = 1'b1;
        #0.1;
        chk("R9 done irq enabled", int'(done_irq), 1);
        chk("R9 empty irq with flag low", int'(empty_irq), 0);
        done_ie = 1'b0;
        #0.1;
        chk("R9 done irq masked", int'(done_irq), 0);

        // R8: clear by pulse.
        @(negedge clk);
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
        chk("R8 quiet cleared", int'(done_flag), 0);

        // R10: re-enable sends the held char.
        tx_enable = 1'b1;
        sample_frame(vb, lb, L, L / 2 + 1, -1, 1, "R10 held char sent");
        chk("R9 empty irq with flag high", int'(empty_irq), 1);
        empty_ie = 1'b0;
        #0.1;
        chk("R9 empty irq masked", int'(empty_irq), 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule